// File: doc/BRIEF.md
# Framed Serial Receiver with Error Check

This block takes a single-wire serial stream, one bit per rising clock edge with no oversampling, and turns each ten-bit frame back into a parallel word. The line rests at 0 between frames. A 1 seen while the receiver is idle is the frame's leading marker. Seven payload bits follow, least significant first, then a check bit, then a closing bit that must be 1. The check bit, in the default configuration, is 1 exactly when the payload holds an odd number of ones.

When a frame closes, the receiver judges it. A good frame replaces the parallel output and raises a one-cycle valid pulse. A bad frame, with a wrong check bit or a closing bit of 0, raises a one-cycle error pulse and leaves the output untouched. The receiver then hunts for the next leading 1, which may arrive on the very next bit. A configurable number of register stages (default one) brings the line into the clock domain. The sense of the check bit can be inverted by a parameter.

Top module: `serial_frame_rx`

## Requirements
- R1: A synchronous active-high reset clears the parallel output to 0, holds both flags at 0 and returns the receiver to idle, abandoning any frame in progress.
- R2: While idle, a 0 on the line starts nothing. A 1 starts a frame that occupies exactly ten line bits (the leading 1, seven payload bits, the check bit, the closing bit), one per clock.
- R3: The first payload bit after the leading 1 lands in output bit 0 and the seventh in output bit 6.
- R4: With ODD_PARITY=0, the check bit must equal 1 exactly when the payload has an odd count of ones. With ODD_PARITY=1 the required value is inverted. A mismatch marks the frame bad.
- R5: A closing bit of 0 marks the frame bad.
- R6: A good frame copies the received payload to the parallel output and raises the valid flag.
- R7: A bad frame raises the error flag, keeps the valid flag at 0 and leaves the parallel output at its previous value.
- R8: The valid or error flag is high for exactly one cycle. It becomes visible SYNC_STAGES+1 rising edges after the closing bit is placed on the line, which is one cycle after the receiver samples that bit.
- R9: A leading 1 placed directly after a closing bit, with no idle bit between them, starts the next frame.
- R10: The valid and error flags are never high together, and the parallel output changes only in a cycle where valid is high or just after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one line bit per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line, idle low |
| data_o | output | DATA_W (7) | Last payload received without error |
| valid_o | output | 1 | One-cycle pulse on a good frame |
| err_o | output | 1 | One-cycle pulse on a bad frame |

## Verification
The bench builds the receiver with its defaults: seven payload bits, one synchronizer stage and the check bit set on an odd count of ones. That configuration exercises the exact pulse latency of two edges after the closing bit, and both check-bit senses through deliberately flipped check bits. It also covers frames that follow each other with no idle bit, and a reset that lands in the middle of a frame. Sweeping the payload across all-zero, all-one, alternating and single-bit words shows that the bit order and the hold-on-error behaviour are correct at every output position.

// File: rtl/serial_frame_rx_pkg.sv
package serial_frame_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_DATA  = 2'd1,
    RX_CHECK = 2'd2,
    RX_CLOSE = 2'd3
  } rx_phase_e;

  // Required check bit given the payload ones-count parity and the sense.
  function automatic logic required_check(input logic ones_odd, input logic odd_sense);
    return ones_odd ^ odd_sense;
  endfunction

  // A frame is good when its check bit matches and its closing bit is high.
  function automatic logic frame_good(input logic ones_odd, input logic check_bit,
                                      input logic close_bit, input logic odd_sense);
    return (check_bit == required_check(ones_odd, odd_sense)) && close_bit;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= '0;
        else if (STAGES == 1) stage_q <= d_i;
        else stage_q <= {stage_q[STAGES-2:0], d_i};
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/srx_seq.sv
module srx_seq
  import serial_frame_rx_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_i,
  output logic frame_start_o,
  output logic shift_en_o,
  output logic check_cap_o,
  output logic close_cap_o,
  output logic busy_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  rx_phase_e         phase_q, phase_d;
  logic [CNT_W-1:0]  idx_q, idx_d;

  always_comb begin
    phase_d       = phase_q;
    idx_d         = idx_q;
    frame_start_o = 1'b0;
    shift_en_o    = 1'b0;
    check_cap_o   = 1'b0;
    close_cap_o   = 1'b0;
    unique case (phase_q)
      RX_IDLE: begin
        if (bit_i) begin
          frame_start_o = 1'b1;
          phase_d       = RX_DATA;
          idx_d         = '0;
        end
      end
      RX_DATA: begin
        shift_en_o = 1'b1;
        if (idx_q == LAST_IDX) begin
          phase_d = RX_CHECK;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      RX_CHECK: begin
        check_cap_o = 1'b1;
        phase_d     = RX_CLOSE;
      end
      RX_CLOSE: begin
        close_cap_o = 1'b1;
        phase_d     = RX_IDLE;
      end
      default: phase_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= RX_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o = (phase_q != RX_IDLE);
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath #(
  parameter int DATA_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bit_i,
  input  logic              frame_start_i,
  input  logic              shift_en_i,
  input  logic              check_cap_i,
  output logic [DATA_W-1:0] word_o,
  output logic              ones_odd_o,
  output logic              check_bit_o
);
  logic [DATA_W-1:0] word_q;
  logic              odd_q;
  logic              check_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      word_q  <= '0;
      odd_q   <= 1'b0;
      check_q <= 1'b0;
    end else begin
      if (frame_start_i) odd_q <= 1'b0;
      else if (shift_en_i) odd_q <= odd_q ^ bit_i;
      if (shift_en_i) begin
        if (DATA_W == 1) word_q <= bit_i;
        else word_q <= {bit_i, word_q[DATA_W-1:1]};
      end
      if (check_cap_i) check_q <= bit_i;
    end
  end

  assign word_o      = word_q;
  assign ones_odd_o  = odd_q;
  assign check_bit_o = check_q;
endmodule

// File: rtl/srx_result.sv
module srx_result
  import serial_frame_rx_pkg::*;
#(
  parameter int DATA_W     = 7,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              close_cap_i,
  input  logic              close_bit_i,
  input  logic              ones_odd_i,
  input  logic              check_bit_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              good_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  assign good_o = frame_good(ones_odd_i, check_bit_i, close_bit_i, ODD_PARITY);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= close_cap_i &&  good_o;
      err_o   <= close_cap_i && !good_o;
      if (close_cap_i && good_o) data_o <= word_i;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int DATA_W      = 7,
  parameter int SYNC_STAGES = 1,
  parameter bit ODD_PARITY  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  logic              line_s;
  logic              frame_start;
  logic              shift_en;
  logic              check_cap;
  logic              close_seen;
  logic              busy;
  logic [DATA_W-1:0] word;
  logic              ones_odd;
  logic              check_bit;
  logic              frame_ok;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(line_i), .q_o(line_s)
  );

  srx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .bit_i(line_s),
    .frame_start_o(frame_start), .shift_en_o(shift_en),
    .check_cap_o(check_cap), .close_cap_o(close_seen), .busy_o(busy)
  );

  srx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i(clk_i), .rst_i(rst_i), .bit_i(line_s),
    .frame_start_i(frame_start), .shift_en_i(shift_en), .check_cap_i(check_cap),
    .word_o(word), .ones_odd_o(ones_odd), .check_bit_o(check_bit)
  );

  srx_result #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_res (
    .clk_i(clk_i), .rst_i(rst_i), .close_cap_i(close_seen), .close_bit_i(line_s),
    .ones_odd_i(ones_odd), .check_bit_i(check_bit), .word_i(word),
    .good_o(frame_ok), .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 7
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              err_o,
  input logic              frame_start,
  input logic              close_seen,
  input logic              busy
);
  localparam int SPAN = DATA_W + 2;
  localparam int GW   = $clog2(SPAN + 2);

  logic [GW-1:0] span_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) span_q <= '0;
    else if (frame_start) span_q <= GW'(1);
    else if (close_seen) span_q <= '0;
    else if (span_q != '0) span_q <= span_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!valid_o && !err_o && data_o == '0));

  // R2
  frame_span_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    close_seen |-> (span_q == GW'(SPAN)));

  // R2
  start_enters_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start |=> busy);

  // R8
  verdict_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    close_seen |=> (valid_o || err_o));

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> !err_o);

  // R10
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_o && err_o));

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_o && !$past(rst_i)) |-> $stable(data_o));
endmodule

bind serial_frame_rx srx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .data_o(data_o), .valid_o(valid_o), .err_o(err_o),
  .frame_start(frame_start), .close_seen(close_seen), .busy(busy)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  localparam int W    = 7;
  localparam int SYNC = 1;
  localparam int WD   = 100000;

  typedef struct {
    bit              ok;
    logic [W-1:0]    data;
    int unsigned     at;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         line = 1'b0;
  logic [W-1:0] data_o;
  logic         valid_o, err_o;

  int unsigned  cyc = 0;
  int           n_run = 0;
  int           n_fail = 0;
  exp_t         expq[$];
  logic [W-1:0] hold = '0;
  bit           done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_frame_rx #(.DATA_W(W), .SYNC_STAGES(SYNC), .ODD_PARITY(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst), .line_i(line),
    .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive_bit(input logic b, output int unsigned at);
    @(negedge clk);
    line = b;
    at = cyc;
  endtask

  task automatic idle(input int n);
    int unsigned t;
    for (int i = 0; i < n; i++) drive_bit(1'b0, t);
  endtask

  // Driver: sends one frame and pushes the expected verdict.
  task automatic send_frame(input logic [W-1:0] d, input bit flip_chk, input logic close_b);
    int unsigned t;
    logic        chk;
    exp_t        e;
    chk = (^d) ^ flip_chk;
    drive_bit(1'b1, t);
    for (int i = 0; i < W; i++) drive_bit(d[i], t);
    drive_bit(chk, t);
    drive_bit(close_b, t);
    e.ok = !flip_chk && close_b;
    if (e.ok) hold = d;
    e.data = hold;
    e.at = t + 1 + SYNC;
    expq.push_back(e);
  endtask

  // Monitor: compares every verdict pulse against the scoreboard.
  always @(negedge clk) begin
    if (!rst && (valid_o || err_o)) begin
      check(!(valid_o && err_o), "R10 flags together", {valid_o, err_o}, 2);
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected verdict", {valid_o, err_o}, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(valid_o == e.ok, e.ok ? "R6 valid on good frame" : "R4/R5 bad frame flagged",
              valid_o, e.ok);
        check(err_o == !e.ok, e.ok ? "R6 no error" : "R7 error pulse", err_o, !e.ok);
        check(data_o == e.data, e.ok ? "R3 payload order" : "R7 output held", data_o, e.data);
        check(cyc == e.at, "R8 verdict latency", cyc, e.at);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc >= WD) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(data_o == '0 && !valid_o && !err_o, "R1 reset state", {data_o, valid_o, err_o}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R2: quiet line starts nothing (monitor flags any pulse)
    idle(20);
    check(expq.size() == 0 && data_o == '0, "R2 idle line", data_o, 0);
    // R3 R6: assorted payloads, R4 sense of check bit
    send_frame(7'h55, 0, 1'b1); idle(3);
    send_frame(7'h01, 0, 1'b1); idle(2);
    send_frame(7'h40, 0, 1'b1); idle(2);
    send_frame(7'h7F, 0, 1'b1); idle(2);
    send_frame(7'h00, 0, 1'b1); idle(2);
    send_frame(7'h2A, 0, 1'b1); idle(2);
    // R4: wrong check bit, odd and even payloads
    send_frame(7'h13, 1, 1'b1); idle(2);
    send_frame(7'h11, 1, 1'b1); idle(2);
    // R5: closing bit low, and both faults together
    send_frame(7'h3C, 0, 1'b0); idle(2);
    send_frame(7'h0F, 1, 1'b0); idle(2);
    // R9: back-to-back frames, including after a bad one
    send_frame(7'h66, 0, 1'b1);
    send_frame(7'h19, 0, 1'b1);
    send_frame(7'h70, 1, 1'b1);
    send_frame(7'h0B, 0, 1'b1); idle(4);
    // R3: sweep of single-bit and computed payloads
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] v;
      v = (k < W) ? W'(1 << k) : W'((k * 37 + 11) & 7'h7F);
      send_frame(v, (k % 5) == 3, 1'b1);
      idle(k % 3);
    end
    idle(6);
    // R1: reset in the middle of a frame
    begin
      int unsigned t;
      drive_bit(1'b1, t);
      drive_bit(1'b1, t);
      drive_bit(1'b0, t);
      @(negedge clk); rst = 1'b1; line = 1'b0;
      repeat (3) @(negedge clk);
      check(data_o == '0 && !valid_o && !err_o, "R1 reset mid-frame", data_o, 0);
      rst = 1'b0;
      hold = '0;
    end
    idle(12);
    check(data_o == '0, "R1 abandoned frame gives no output", data_o, 0);
    send_frame(7'h5A, 0, 1'b1); idle(6);
    check(expq.size() == 0, "R8 every frame produced a verdict", expq.size(), 0);
    check(data_o == 7'h5A, "R6 final output", data_o, 7'h5A);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule